// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a two-bank synchronous graphics DRAM. It takes the memory from power-on to an idle, programmed state. After reset it keeps the clock-enable and data-mask pins high and puts NOP on the command bus for a pause computed from the clock frequency. It then closes both banks with a precharge-all command. After that it programs the mode register and issues a configurable number of auto-refresh commands. Two orders are supported: the mode-register set can come before the refresh burst or after it.

Each command is held on the pins for exactly one clock. Between commands the block waits a fixed number of cycles: the precharge recovery time after the precharge, the mode-set recovery time after the mode-register set, and the refresh cycle time after each refresh. When the last wait has elapsed it raises a sticky done flag and releases the data mask. From then on the normal memory controller takes over the command bus.

All pin outputs come straight from flops. The pins therefore trail the internal state by one clock, and they show NOP with CKE and DQM high while reset is asserted.

Top module: `sdram_boot_seq`

## Requirements
- R1: While reset is asserted the pins show NOP, CKE and DQM are high, done is low, and the address and bank are zero. Commands are encoded on {cs_n, ras_n, cas_n, we_n} as NOP 0111, precharge 0010, auto-refresh 0001 and mode-register set 0000.
- R2: For the first CLK_MHZ*PAUSE_US clock edges after reset release, the pins carry only NOP with CKE and DQM high. CKE stays high at all times.
- R3: The first command is a precharge on edge CLK_MHZ*PAUSE_US+1. It drives address bit AP_BIT high, all other address bits low, and bank 0.
- R4: With ref_first low, the command order is precharge, then mode-register set, then N_REF auto-refreshes.
- R5: With ref_first high, the command order is precharge, then N_REF auto-refreshes, then mode-register set.
- R6: The mode-register set drives MODE_WORD on the address bus and bank 0. Every auto-refresh drives address 0.
- R7: The next command follows exactly T_RP cycles after a precharge, T_MRD cycles after a mode-register set and T_RC cycles after an auto-refresh.
- R8: Every command lasts exactly one cycle. The cycle after a command is always NOP.
- R9: done rises exactly T_MRD or T_RC cycles after the final command, whichever wait follows that command. DQM falls in the same cycle. From then until reset, done stays high and the pins stay NOP.
- R10: ref_first is captured at the clock edge that puts the precharge on the pins. Changes to it after that edge do not affect the order.
- R11: Exactly N_REF auto-refresh commands are issued per sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; asserted asynchronously, released synchronously |
| ref_first | input | 1 | 1: refresh burst before mode-register set; 0: mode-register set first |
| cke | output | 1 | Clock enable to the memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | 1 | Bank select |
| addr | output | ADDR_W | Address bus |
| dqm | output | 1 | Data mask, high until done |
| done | output | 1 | Sticky flag: initialization complete |

## Verification
The bench builds the block with CLK_MHZ=1 and PAUSE_US=200, which gives a 200-cycle pause. With this pause, all four runs fit easily into the cycle budget while the full pause window is still checked on every edge. N_REF=9 moves the refresh count off its floor, so an off-by-one in the refresh loop cannot pass. T_RP=3, T_MRD=2 and T_RC=5 are distinct values, so a wait taken from the wrong parameter shows up as a spacing error. Both order settings are run, and two of the runs toggle ref_first just after the precharge to confirm that the captured value holds.

// File: rtl/sdram_boot_pkg.sv
package sdram_boot_pkg;

  // Pin code {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_MRS = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_NOP = 4'b0111
  } cmd_e;

  typedef enum logic [2:0] {
    ST_PAUSE = 3'd0,
    ST_PRE   = 3'd1,
    ST_MRS   = 3'd2,
    ST_REF   = 3'd3,
    ST_WAIT  = 3'd4,
    ST_DONE  = 3'd5
  } state_e;

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/boot_timer.sv
module boot_timer #(
  parameter int CW      = 16,
  parameter int RST_VAL = 100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    if (load) cnt_d = load_val;
    else      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= CW'(RST_VAL);
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);

  AST_TIMER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (expired && !load) |=> expired); // R7

endmodule

// File: rtl/boot_fsm.sv
module boot_fsm
  import sdram_boot_pkg::*;
#(
  parameter int T_RP  = 3,
  parameter int T_MRD = 2,
  parameter int T_RC  = 7,
  parameter int N_REF = 8,
  parameter int CW    = 16,
  parameter int RW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ref_first,
  input  logic          expired,
  output logic          load,
  output logic [CW-1:0] load_val,
  output state_e        state_o
);

  state_e        state_q, state_d;
  state_e        after_q, after_d;
  logic          order_q, order_d;
  logic [RW-1:0] refs_q, refs_d;
  logic [RW-1:0] refs_inc;

  assign refs_inc = refs_q + 1'b1;

  always_comb begin
    state_d  = state_q;
    after_d  = after_q;
    order_d  = order_q;
    refs_d   = refs_q;
    load     = 1'b0;
    load_val = '0;
    unique case (state_q)
      ST_PAUSE: if (expired) state_d = ST_PRE;
      ST_PRE: begin
        order_d  = ref_first;
        load     = 1'b1;
        load_val = CW'(T_RP - 2);
        state_d  = ST_WAIT;
        after_d  = ref_first ? ST_REF : ST_MRS;
      end
      ST_MRS: begin
        load     = 1'b1;
        load_val = CW'(T_MRD - 2);
        state_d  = ST_WAIT;
        after_d  = order_q ? ST_DONE : ST_REF;
      end
      ST_REF: begin
        refs_d   = refs_inc;
        load     = 1'b1;
        load_val = CW'(T_RC - 2);
        state_d  = ST_WAIT;
        if (refs_inc < RW'(N_REF)) after_d = ST_REF;
        else                       after_d = order_q ? ST_MRS : ST_DONE;
      end
      ST_WAIT: if (expired) state_d = after_q;
      ST_DONE: state_d = ST_DONE;
      default: state_d = ST_PAUSE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_PAUSE;
      after_q <= ST_PRE;
      order_q <= 1'b0;
      refs_q  <= '0;
    end else begin
      state_q <= state_d;
      after_q <= after_d;
      order_q <= order_d;
      refs_q  <= refs_d;
    end
  end

  assign state_o = state_q;

  AST_REF_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    refs_q <= RW'(N_REF)); // R11
  AST_DONE_REFS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DONE) |-> (refs_q == RW'(N_REF))); // R11
  AST_ORDER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_PAUSE && state_q != ST_PRE && $past(state_q) != ST_PRE) |-> $stable(order_q)); // R10

endmodule

// File: rtl/boot_cmd_out.sv
module boot_cmd_out
  import sdram_boot_pkg::*;
#(
  parameter int                ADDR_W    = 11,
  parameter int                AP_BIT    = 10,
  parameter logic [ADDR_W-1:0] MODE_WORD = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  state_e            state_i,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic              ba,
  output logic [ADDR_W-1:0] addr,
  output logic              dqm,
  output logic              done
);

  cmd_e              cmd_d, cmd_q;
  logic [ADDR_W-1:0] addr_d, addr_q;
  logic              done_d, done_q;
  logic              cke_q, dqm_q;

  always_comb begin
    cmd_d  = CMD_NOP;
    addr_d = '0;
    unique case (state_i)
      ST_PRE: begin
        cmd_d          = CMD_PRE;
        addr_d[AP_BIT] = 1'b1;
      end
      ST_MRS: begin
        cmd_d  = CMD_MRS;
        addr_d = MODE_WORD;
      end
      ST_REF:  cmd_d = CMD_REF;
      default: cmd_d = CMD_NOP;
    endcase
    done_d = (state_i == ST_DONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= CMD_NOP;
      addr_q <= '0;
      done_q <= 1'b0;
      cke_q  <= 1'b1;
      dqm_q  <= 1'b1;
    end else begin
      cmd_q  <= cmd_d;
      addr_q <= addr_d;
      done_q <= done_d;
      cke_q  <= 1'b1;
      dqm_q  <= !done_d;
    end
  end

  assign {cs_n, ras_n, cas_n, we_n} = cmd_q;
  assign addr = addr_q;
  assign ba   = 1'b0;
  assign cke  = cke_q;
  assign dqm  = dqm_q;
  assign done = done_q;

  AST_CMD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q != CMD_NOP) |=> (cmd_q == CMD_NOP)); // R8
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> done_q); // R9
  AST_QUIET_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (cmd_q == CMD_NOP && !dqm_q)); // R9

endmodule

// File: rtl/sdram_boot_seq.sv
module sdram_boot_seq
  import sdram_boot_pkg::*;
#(
  parameter int                CLK_MHZ   = 100,
  parameter int                PAUSE_US  = 200,
  parameter int                T_RP      = 3,
  parameter int                T_MRD     = 2,
  parameter int                T_RC      = 7,
  parameter int                N_REF     = 8,
  parameter int                ADDR_W    = 11,
  parameter int                AP_BIT    = 10,
  parameter logic [ADDR_W-1:0] MODE_WORD = 11'h030
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_first,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic              ba,
  output logic [ADDR_W-1:0] addr,
  output logic              dqm,
  output logic              done
);

  localparam int PAUSE_CYC = CLK_MHZ * PAUSE_US;
  localparam int MAX_WAIT  = max_of(max_of(PAUSE_CYC, T_RC), max_of(T_RP, T_MRD));
  localparam int CW        = $clog2(MAX_WAIT + 1);
  localparam int RW        = $clog2(N_REF + 1);

  logic          tmr_load;
  logic [CW-1:0] tmr_val;
  logic          tmr_expired;
  state_e        fsm_state;

  boot_timer #(
    .CW      (CW),
    .RST_VAL (PAUSE_CYC - 1)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  boot_fsm #(
    .T_RP  (T_RP),
    .T_MRD (T_MRD),
    .T_RC  (T_RC),
    .N_REF (N_REF),
    .CW    (CW),
    .RW    (RW)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .ref_first (ref_first),
    .expired   (tmr_expired),
    .load      (tmr_load),
    .load_val  (tmr_val),
    .state_o   (fsm_state)
  );

  boot_cmd_out #(
    .ADDR_W    (ADDR_W),
    .AP_BIT    (AP_BIT),
    .MODE_WORD (MODE_WORD)
  ) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .state_i (fsm_state),
    .cke     (cke),
    .cs_n    (cs_n),
    .ras_n   (ras_n),
    .cas_n   (cas_n),
    .we_n    (we_n),
    .ba      (ba),
    .addr    (addr),
    .dqm     (dqm),
    .done    (done)
  );

  AST_CKE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    cke); // R2
  AST_NO_EARLY_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (fsm_state == ST_PAUSE) |=> ({cs_n, ras_n, cas_n, we_n} == CMD_NOP && dqm)); // R2

endmodule

// File: tb/sim_sdram_boot_seq.sv
module sim_sdram_boot_seq;

  localparam int  PERIOD  = 10;
  localparam int  CLK_MHZ = 1;
  localparam int  PAUSE_US = 200;
  localparam int  P       = CLK_MHZ * PAUSE_US;
  localparam int  T_RP    = 3;
  localparam int  T_MRD   = 2;
  localparam int  T_RC    = 5;
  localparam int  N_REF   = 9;
  localparam int  ADDR_W  = 11;
  localparam int  AP_BIT  = 10;
  localparam logic [ADDR_W-1:0] MODE = 11'h233;
  localparam logic [3:0] C_NOP = 4'b0111, C_PRE = 4'b0010, C_REF = 4'b0001, C_MRS = 4'b0000;

  typedef struct {
    logic [3:0]        cmd;
    int                at;
    logic [ADDR_W-1:0] adr;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_first = 1'b0;
  logic cke, cs_n, ras_n, cas_n, we_n, ba, dqm, done;
  logic [ADDR_W-1:0] addr;

  int total = 0;
  int bad = 0;
  int edge_n = 0;
  int exp_done_at = 0;
  int ref_seen = 0;
  bit armed = 1'b0;
  bit cur_order = 1'b0;
  bit pause_ok = 1'b1;
  bit tail_ok = 1'b1;
  logic [3:0] prev_cmd = 4'b0111;
  item_t q[$];

  always #(PERIOD/2) clk = ~clk;

  sdram_boot_seq #(
    .CLK_MHZ (CLK_MHZ), .PAUSE_US (PAUSE_US), .T_RP (T_RP), .T_MRD (T_MRD),
    .T_RC (T_RC), .N_REF (N_REF), .ADDR_W (ADDR_W), .AP_BIT (AP_BIT), .MODE_WORD (MODE)
  ) u0 (
    .clk (clk), .rst_n (rst_n), .ref_first (ref_first), .cke (cke),
    .cs_n (cs_n), .ras_n (ras_n), .cas_n (cas_n), .we_n (we_n),
    .ba (ba), .addr (addr), .dqm (dqm), .done (done)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at edge %0d", tag, act, exp, edge_n);
    end
  endtask

  // Driver: expected command stream for one order setting
  task automatic push_plan(input bit order);
    int t;
    item_t it;
    q.delete();
    t = P + 1;
    it.cmd = C_PRE; it.at = t; it.adr = ADDR_W'(1) << AP_BIT; q.push_back(it);
    t += T_RP;
    if (!order) begin
      it.cmd = C_MRS; it.at = t; it.adr = MODE; q.push_back(it);
      t += T_MRD;
    end
    for (int i = 0; i < N_REF; i++) begin
      it.cmd = C_REF; it.at = t; it.adr = '0; q.push_back(it);
      t += T_RC;
    end
    if (order) begin
      it.cmd = C_MRS; it.at = t; it.adr = MODE; q.push_back(it);
      t += T_MRD;
    end
    exp_done_at = t;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) edge_n <= 0;
    else        edge_n <= edge_n + 1;
  end

  // Monitor: decode pins every cycle, compare against the queue
  always @(negedge clk) begin
    logic [3:0] c;
    item_t it;
    c = {cs_n, ras_n, cas_n, we_n};
    if (rst_n && armed && edge_n > 0) begin
      if (edge_n <= P) begin
        if (c != C_NOP || !cke || !dqm) pause_ok = 1'b0;
        if (edge_n == P) check(pause_ok, "R2 pause NOP/CKE/DQM", pause_ok, 1);
      end
      if (!cke) check(1'b0, "R2 cke", cke, 1);
      if (c != C_NOP) begin
        check(prev_cmd == C_NOP, "R8 gap before cmd", prev_cmd, C_NOP);
        if (c == C_REF) ref_seen++;
        if (q.size() == 0) begin
          check(1'b0, cur_order ? "R5 extra cmd" : "R4 extra cmd", c, C_NOP);
        end else begin
          it = q.pop_front();
          check(c == it.cmd, cur_order ? "R5 order" : "R4 order", c, it.cmd);
          check(edge_n == it.at, "R7 spacing", edge_n, it.at);
          check(addr == it.adr && ba == 1'b0, (it.cmd == C_MRS) ? "R6 address" : "R3 address",
                addr, it.adr);
        end
      end
      if (edge_n == exp_done_at - 1) check(!done && dqm, "R9 done early", done, 0);
      if (edge_n == exp_done_at)     check(done && !dqm, "R9 done rise", done, 1);
      if (edge_n > exp_done_at && (!done || c != C_NOP || dqm)) tail_ok = 1'b0;
      prev_cmd = c;
    end
  end

  task automatic run_once(input bit order, input bit flip);
    rst_n = 1'b0;
    armed = 1'b0;
    ref_first = order;
    cur_order = order;
    repeat (3) @(negedge clk);
    check({cs_n, ras_n, cas_n, we_n} == C_NOP, "R1 reset cmd", {cs_n, ras_n, cas_n, we_n}, C_NOP);
    check(cke && dqm && !done && addr == '0 && ba == 1'b0, "R1 reset pins",
          {cke, dqm, done}, 3'b110);
    push_plan(order);
    ref_seen = 0;
    pause_ok = 1'b1;
    tail_ok = 1'b1;
    prev_cmd = C_NOP;
    armed = 1'b1;
    rst_n = 1'b1;
    if (flip) begin
      wait (edge_n == P + 1);
      @(negedge clk);
      ref_first = !order;
    end
    wait (edge_n >= exp_done_at + 20);
    @(negedge clk);
    check(q.size() == 0, flip ? "R10 stream complete" : (order ? "R5 complete" : "R4 complete"),
          q.size(), 0);
    check(ref_seen == N_REF, "R11 refresh count", ref_seen, N_REF);
    check(tail_ok, "R9 sticky done/NOP", tail_ok, 1);
    armed = 1'b0;
  endtask

  initial begin
    run_once(1'b0, 1'b0);
    run_once(1'b1, 1'b0);
    run_once(1'b1, 1'b1); // R10
    run_once(1'b0, 1'b1); // R10
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(PERIOD * 100000);
    total++;
    bad++;
    $display("FAIL watchdog expired at edge %0d", edge_n);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule